// File: doc/BRIEF.md
# Interrupt Message Generator

This block converts interrupt requests raised inside a device into posted memory-write messages. Software sets a target address, a 16-bit base data word, a global enable and the number of enabled vectors. The enabled count is always a power of two from 1 to 32. When a request is pending and the block is allowed to send, it builds one write and offers it on an outbound channel with a valid/ready handshake. The write's address is the shared target. Its data word is the base word with its low bits replaced by the vector number.

Requests for vector numbers above the enabled range fold onto an enabled vector, by keeping only the low bits of the number. The block must never let an interrupt message overtake a data write that entered the shared outbound queue before it. To enforce this it tracks how many data writes are still waiting in that queue. While that count is not zero, it keeps the message back.

Top module: `msi_msg_gen`

## Requirements
- R1: After reset no message is offered (`msg_valid` low) and no request is pending. Setting the enable with no request raised produces no message.
- R2: Configuration writes select a register with `cfg_sel`. Value 0 loads the target address from `cfg_wdata[31:0]`. Value 1 loads the base word from `cfg_wdata[15:0]`. Value 2 loads control: bit 0 is the enable, and bits 3:1 hold L, the log2 of the enabled vector count. An L of 6 or 7 acts as 5, which enables 32 vectors.
- R3: A message carries the programmed target address in `msg_addr`. `msg_data[31:16]` is zero. `msg_data[15:0]` equals the base word with its low L bits replaced by the vector number.
- R4: A request on `irq_req[v]` marks vector `v mod 2^L` as pending.
- R5: When several vectors are pending, the lowest-numbered one is sent first.
- R6: Once `msg_valid` rises, it stays high until a cycle with `msg_ready` high. `msg_addr` and `msg_data` hold steady during that time, even if the configuration is rewritten. A pending bit clears only on the handshake that sends it.
- R7: While the enable is clear, requests stay pending and no new message is offered. Setting the enable then sends them.
- R8: A data-write entry (`dma_enq`) adds one to the outstanding count, and a data-write exit (`dma_deq`) removes one. An entry and an exit in the same cycle leave the count unchanged, and an exit at a count of zero is ignored. No message is offered while the count is non-zero.
- R9: A request for a vector that arrives in the same cycle as that vector's handshake is kept pending and produces a further message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| irq_req | input | 32 | One-cycle request pulses, one bit per requested vector |
| dma_enq | input | 1 | A data write entered the shared outbound queue |
| dma_deq | input | 1 | A data write left the shared outbound queue |
| msg_valid | output | 1 | Interrupt message offered |
| msg_ready | input | 1 | Outbound channel accepts the message |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Two things can fall in the same cycle: the handshake that clears a vector's pending bit, and a fresh request for that same vector. The bench provokes this by pulsing the request in the exact cycle `msg_ready` meets `msg_valid`. It passes only if a second message for that vector follows. A second overlap is a data-write entry together with an exit while a message waits on the ordering count. Here the bench checks that the message stays held until the last outstanding write has left.

// File: rtl/msi_pkg.sv
// Shared sizes and helpers for the interrupt message generator.
// Assumes at most 32 vectors, as the message format allows.
package msi_pkg;
    localparam int NUM_VEC   = 32;
    localparam int VEC_W     = $clog2(NUM_VEC);
    localparam int LG_W      = 3;
    localparam int LG_MAX    = VEC_W;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 32;
    localparam int MSG_W     = 32;
    localparam int SEL_W     = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_ADDR = 2'd0,
        SEL_BASE = 2'd1,
        SEL_CTRL = 2'd2
    } cfg_sel_e;
endpackage

// File: rtl/msi_cfg.sv
// Configuration registers: target address, base data word, enable and
// log2 vector count. Assumes writes come one per cycle; no read path.
module msi_cfg
    import msi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] base,
    output logic              en,
    output logic [VEC_W-1:0]  vmask
);
    logic [LG_W-1:0] lg_q;
    logic [LG_W-1:0] lg_eff;

    // Load the selected register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr <= '0;
            base     <= '0;
            en       <= 1'b0;
            lg_q     <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_ADDR: tgt_addr <= wdata;
                SEL_BASE: base     <= wdata[DATA_W-1:0];
                SEL_CTRL: begin
                    en   <= wdata[0];
                    lg_q <= wdata[LG_W:1];
                end
                default: ;
            endcase
        end
    end

    // Clamp the count code and turn it into a low-bit vector mask.
    always_comb begin
        lg_eff = (lg_q > LG_W'(LG_MAX)) ? LG_W'(LG_MAX) : lg_q;
        vmask  = VEC_W'((32'd1 << lg_eff) - 32'd1);
    end
endmodule

// File: rtl/msi_pending.sv
// Pending vector register with aliasing and lowest-first selection.
// A bit is set by a (masked) request and cleared only by an acknowledge;
// a set in the same cycle as its clear wins.
module msi_pending
    import msi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] req,
    input  logic [VEC_W-1:0]   vmask,
    input  logic               ack,
    input  logic [VEC_W-1:0]   ack_vec,
    output logic [NUM_VEC-1:0] pend,
    output logic               any,
    output logic [VEC_W-1:0]   low_vec
);
    logic [NUM_VEC-1:0] set_v;
    logic [NUM_VEC-1:0] clr_v;

    // Fold each request onto its enabled vector.
    always_comb begin
        set_v = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (req[i]) set_v[VEC_W'(i) & vmask] = 1'b1;
        end
        clr_v = ack ? (NUM_VEC'(1) << ack_vec) : '0;
    end

    // Update pending bits: clear on acknowledge, then apply new requests.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_v) | set_v;
    end

    // Pick the lowest-numbered pending vector.
    always_comb begin
        any     = |pend;
        low_vec = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (pend[i]) low_vec = VEC_W'(i);
        end
    end

    // R6: without an acknowledge no pending bit may drop.
    p_keep_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: rtl/msi_order.sv
// Counts data writes still waiting in the shared outbound queue ahead of
// any message. Assumes the queue never holds 2**CNT_W-1 or more writes;
// the count saturates there and ignores exits at zero.
module msi_order #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enq,
    input  logic deq,
    output logic clear
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    logic [CNT_W-1:0] cnt_q;

    // Track outstanding data writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({enq, deq})
                2'b10: if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                2'b01: if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
                default: ;
            endcase
        end
    end

    assign clear = (cnt_q == '0);
endmodule

// File: rtl/msi_msg_gen.sv
// Interrupt message generator top. Launches one message at a time from
// the lowest pending vector when enabled and no earlier data write waits,
// captures address and data at launch and holds them until accepted.
module msi_msg_gen
    import msi_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic [NUM_VEC-1:0] irq_req,
    input  logic               dma_enq,
    input  logic               dma_deq,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [ADDR_W-1:0]  msg_addr,
    output logic [MSG_W-1:0]   msg_data
);
    logic [ADDR_W-1:0]  tgt_addr;
    logic [DATA_W-1:0]  base;
    logic               en;
    logic [VEC_W-1:0]   vmask;
    logic [NUM_VEC-1:0] pend;
    logic               any;
    logic [VEC_W-1:0]   low_vec;
    logic               clear;
    logic [VEC_W-1:0]   out_vec;
    logic               ack;
    logic               launch;
    logic [DATA_W-1:0]  data16;

    msi_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .tgt_addr(tgt_addr), .base(base),
        .en(en), .vmask(vmask)
    );

    msi_pending u_pend (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .vmask(vmask),
        .ack(ack), .ack_vec(out_vec), .pend(pend), .any(any),
        .low_vec(low_vec)
    );

    msi_order #(.CNT_W(CNT_W)) u_ord (
        .clk(clk), .rst_n(rst_n), .enq(dma_enq), .deq(dma_deq),
        .clear(clear)
    );

    // Decide launch and build the data word from base and vector.
    always_comb begin
        ack    = msg_valid && msg_ready;
        launch = !msg_valid && en && any && clear;
        data16 = (base & ~{{(DATA_W-VEC_W){1'b0}}, vmask})
               | {{(DATA_W-VEC_W){1'b0}}, low_vec & vmask};
    end

    // Output holding register: capture on launch, release on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            out_vec   <= '0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (launch) begin
            msg_valid <= 1'b1;
            out_vec   <= low_vec;
            msg_addr  <= tgt_addr;
            msg_data  <= {{(MSG_W-DATA_W){1'b0}}, data16};
        end else if (ack) begin
            msg_valid <= 1'b0;
        end
    end

    // R6: an offered message stays put until accepted.
    p_hold_msg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R8: a message only appears when no earlier data write was waiting.
    p_no_overtake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(clear));

    // R7: no message starts while disabled.
    p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(en));

    // R5: nothing lower than the launched vector was pending.
    p_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (($past(pend) & ((NUM_VEC'(1) << out_vec) - NUM_VEC'(1))) == '0));
endmodule

// File: tb/sim_msi_msg_gen.sv
module sim_msi_msg_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] irq_req = '0;
    logic        dma_enq = 1'b0;
    logic        dma_deq = 1'b0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [31:0] msg_addr;
    logic [31:0] msg_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_msg_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .irq_req(irq_req), .dma_enq(dma_enq),
        .dma_deq(dma_deq), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_req(input logic [31:0] bits);
        @(negedge clk);
        irq_req = bits;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic pulse_dma(input bit e, input bit d);
        @(negedge clk);
        dma_enq = e; dma_deq = d;
        @(negedge clk);
        dma_enq = 1'b0; dma_deq = 1'b0;
    endtask

    // Wait at negedges until a message is offered; returns whether one came.
    task automatic wait_msg(output bit got);
        got = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (msg_valid) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // Accept the current message with a one-cycle ready pulse.
    task automatic accept();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_msg(input string req, input logic [31:0] addr, input logic [31:0] data);
        bit got;
        wait_msg(got);
        check(got, req, {31'b0, got}, 32'd1);
        check(msg_addr == addr, req, msg_addr, addr);
        check(msg_data == data, req, msg_data, data);
        accept();
    endtask

    task automatic expect_quiet(input string req, input int cycles);
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(!seen, req, {31'b0, seen}, 32'd0);
    endtask

    task automatic t_reset();
        check(msg_valid == 1'b0, "R1 valid after reset", {31'b0, msg_valid}, 32'd0);
        cfg_write(2'd2, 32'h0000_000B);
        expect_quiet("R1 no message without request", 8);
    endtask

    task automatic t_format();
        cfg_write(2'd0, 32'hFEE0_1000);
        cfg_write(2'd1, 32'hABCD_4120);
        pulse_req(32'h1 << 7);
        expect_msg("R3 address and data", 32'hFEE0_1000, 32'h0000_4127);
        expect_quiet("R3 single message", 4);
    endtask

    task automatic t_alias();
        cfg_write(2'd2, 32'h0000_0005); // L=2, enabled
        cfg_write(2'd1, 32'h0000_4123);
        pulse_req(32'h1 << 13);
        expect_msg("R4 alias 13 onto 1", 32'hFEE0_1000, 32'h0000_4121);
        cfg_write(2'd2, 32'h0000_000F); // L=7 acts as 5
        cfg_write(2'd1, 32'h0000_4100);
        pulse_req(32'h1 << 13);
        expect_msg("R2 clamped count keeps 13", 32'hFEE0_1000, 32'h0000_410D);
    endtask

    task automatic t_priority();
        cfg_write(2'd1, 32'h0);
        pulse_req((32'h1 << 9) | (32'h1 << 3) | (32'h1 << 20));
        expect_msg("R5 first lowest", 32'hFEE0_1000, 32'd3);
        expect_msg("R5 second", 32'hFEE0_1000, 32'd9);
        expect_msg("R5 third", 32'hFEE0_1000, 32'd20);
    endtask

    task automatic t_hold();
        bit got;
        bit moved = 1'b0;
        pulse_req(32'h1 << 2);
        wait_msg(got);
        cfg_write(2'd1, 32'h0000_7700);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!msg_valid || msg_data != 32'd2) moved = 1'b1;
        end
        check(got && !moved, "R6 held until ready", msg_data, 32'd2);
        accept();
        expect_quiet("R6 cleared on handshake", 4);
        cfg_write(2'd1, 32'h0);
    endtask

    task automatic t_disable();
        cfg_write(2'd2, 32'h0000_000A); // L=5, disabled
        pulse_req(32'h1 << 5);
        expect_quiet("R7 nothing while disabled", 10);
        cfg_write(2'd2, 32'h0000_000B);
        expect_msg("R7 sent after enable", 32'hFEE0_1000, 32'd5);
    endtask

    task automatic t_order();
        bit got;
        pulse_dma(1'b0, 1'b1);   // exit at zero: ignored
        pulse_dma(1'b1, 1'b0);
        pulse_dma(1'b1, 1'b0);
        pulse_req(32'h1 << 4);
        expect_quiet("R8 held with two writes", 8);
        pulse_dma(1'b0, 1'b1);
        expect_quiet("R8 held with one write", 5);
        pulse_dma(1'b1, 1'b1);
        expect_quiet("R8 enq and deq together", 5);
        pulse_dma(1'b0, 1'b1);
        wait_msg(got);
        check(got && msg_data == 32'd4, "R8 sent after queue drained", msg_data, 32'd4);
        accept();
    endtask

    task automatic t_collide();
        bit got;
        pulse_req(32'h1 << 6);
        wait_msg(got);
        msg_ready = 1'b1;
        irq_req = 32'h1 << 6;
        @(negedge clk);
        msg_ready = 1'b0;
        irq_req = '0;
        expect_msg("R9 request during handshake", 32'hFEE0_1000, 32'd6);
        expect_quiet("R9 only one repeat", 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_format();
        t_alias();
        t_priority();
        t_hold();
        t_disable();
        t_order();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule